// File: doc/BRIEF.md
# Motion-Threshold Interrupt Latch

This block watches a stream of signed three-axis acceleration samples, one triple per sample strobe. Each sample is compared against a level threshold pair and a pulse threshold. The per-axis results are combined under a programmable polarity rule and fed to a level detector and a pulse-shape detector. The pulse detector can also look for a second pulse inside a time window. Two sticky interrupt flags, each with its own per-axis source bits, record the detections. A source-select field chooses which detector feeds each flag.

Software-facing logic sits outside this block and drives the configuration inputs and the two one-cycle clear strobes. The two flags leave through registered interrupt pins, and those pins can be swapped.

Top module: `motion_irq_latch`

## Requirements
- R1: While `rst` is high at a clock edge, both flags, both source vectors, both pins and the pulse detector are cleared.
- R2: A 1 in `axis_off` (bit 0 X, bit 1 Y, bit 2 Z) removes that axis from both detectors and from the source bits. With all three axes off, nothing is detected.
- R3: An axis is "beyond" when it exceeds its level threshold. With `lvl_neg`=0, a level detection is any enabled axis beyond. With `lvl_neg`=1, a level detection needs every enabled axis not beyond.
- R4: With `thr_split`=0, an axis is beyond when |a| >= `lvl_thr_a`. With `thr_split`=1, it is beyond when a >= `lvl_thr_a` or a <= -`lvl_thr_b`. The pulse threshold always uses |a| >= `pls_thr`, under the same polarity rule selected by `pls_neg`.
- R5: A pulse is a run of 1 to `pls_lat` consecutive strobes with the pulse condition true, followed by a strobe with it false. The detection happens at that closing strobe. Longer runs are discarded once the condition drops. `pls_lat`=0 disables pulse detection.
- R6: When `dbl_win` is nonzero, a second pulse must start within `dbl_win` strobes after the strobe that closed the first pulse. The pulse detection is the close of that second pulse. The first pulse counts as a single-pulse detection.
- R7: `src_sel` sets the flag sources. 00 and 11 give flag1 = level and flag2 = pulse. 01 gives flag1 = pulse and flag2 = level. 10 gives flag1 = single pulse and flag2 = pulse. When `dbl_win` is nonzero, flag1 is always the single-pulse detection.
- R8: A detection ORs its axes into the flag's source vector (bit 0 X, bit 1 Y, bit 2 Z). For a level detection these are the enabled axes meeting the condition on that strobe. For a pulse detection they are the axes meeting it on the strobe where the closing pulse began.
- R9: Flags and source bits are sticky until their clear takes effect. They update at the clock edge that samples the strobe. A detection in the same cycle as a clear leaves the flag set, with only the new axes in its source vector.
- R10: `clr1` clears flag1 and `src1` when `dbl_win` is zero. It is ignored when `dbl_win` is nonzero.
- R11: `clr2` clears flag2 and `src2`. When `dbl_win` is nonzero, it also clears flag1 and `src1` and returns the pulse detector to its idle state.
- R12: After each edge, `irq_pin1` and `irq_pin2` show flag1 and flag2 when `pin_cross` was 0 at that edge, and the swapped pair when it was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe |
| smp_x | input | DW | Signed X sample |
| smp_y | input | DW | Signed Y sample |
| smp_z | input | DW | Signed Z sample |
| axis_off | input | 3 | Per-axis exclusion bits |
| lvl_neg | input | 1 | Level polarity / AND rule |
| thr_split | input | 1 | Separate positive/negative level thresholds |
| lvl_thr_a | input | DW | Level magnitude or positive threshold |
| lvl_thr_b | input | DW | Level negative threshold magnitude |
| pls_neg | input | 1 | Pulse polarity / AND rule |
| pls_thr | input | DW | Pulse magnitude threshold |
| pls_lat | input | LATW | Maximum pulse length in strobes |
| dbl_win | input | WINW | Second-pulse window in strobes, 0 = single |
| src_sel | input | 2 | Flag source selection |
| pin_cross | input | 1 | Swap pin routing |
| clr1 | input | 1 | Write-one clear for flag1 |
| clr2 | input | 1 | Write-one clear for flag2 |
| flag1 | output | 1 | Interrupt flag 1 |
| flag2 | output | 1 | Interrupt flag 2 |
| src1 | output | 3 | Source axes of flag 1 |
| src2 | output | 3 | Source axes of flag 2 |
| irq_pin1 | output | 1 | Registered interrupt pin 1 |
| irq_pin2 | output | 1 | Registered interrupt pin 2 |

## Verification
The assertions assume that clears are one-cycle strobes and that the configuration inputs change only while the pulse detector is idle. They also assume that a clear in double-pulse mode does not coincide with a sample strobe when the check expects both flags low. The stimulus follows these rules: it changes thresholds, modes and windows only after a sequence has closed or after a `clr2` restart. The one place where `clr1` and a strobe share a cycle is the deliberate set-over-clear sweep, which runs in single-pulse mode.

// File: rtl/mtl_pkg.sv
`timescale 1ns/1ps
package mtl_pkg;

  localparam int NAX = 3;

  typedef enum logic [1:0] {
    SRC_LVL_PLS = 2'b00,
    SRC_PLS_LVL = 2'b01,
    SRC_SP_PLS  = 2'b10,
    SRC_RSVD    = 2'b11
  } src_sel_e;

  typedef enum logic [2:0] {
    PS_IDLE   = 3'd0,
    PS_HI1    = 3'd1,
    PS_WAITLO = 3'd2,
    PS_ARM    = 3'd3,
    PS_HI2    = 3'd4
  } pstate_e;

endpackage

// File: rtl/mtl_axis_cmp.sv
`timescale 1ns/1ps
module mtl_axis_cmp #(
  parameter int DW = 8
) (
  input  logic signed [DW-1:0] smp,
  input  logic        [DW-1:0] thr_a,
  input  logic        [DW-1:0] thr_b,
  input  logic        [DW-1:0] pthr,
  input  logic                 split,
  output logic                 lvl_bey,
  output logic                 pls_bey
);

  localparam int XW = DW + 2;

  logic signed [XW-1:0] sx;
  logic signed [XW-1:0] ta;
  logic signed [XW-1:0] tb;
  logic        [DW:0]   mag;

  always_comb begin
    sx = {{2{smp[DW-1]}}, smp};
    ta = $signed({2'b00, thr_a});
    tb = $signed({2'b00, thr_b});
    if (smp[DW-1]) mag = (DW+1)'(-sx);
    else           mag = (DW+1)'(sx);
    if (split) lvl_bey = (sx >= ta) || (sx <= -tb);
    else       lvl_bey = (mag >= {1'b0, thr_a});
    pls_bey = (mag >= {1'b0, pthr});
  end

endmodule

// File: rtl/mtl_pulse_det.sv
`timescale 1ns/1ps
module mtl_pulse_det
  import mtl_pkg::*;
#(
  parameter int LATW = 4,
  parameter int WINW = 4,
  parameter int NA   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stb,
  input  logic            cond,
  input  logic [NA-1:0]   hit,
  input  logic [LATW-1:0] lat,
  input  logic [WINW-1:0] win,
  input  logic            restart,
  output logic            sp_ev,
  output logic            pl_ev,
  output logic [NA-1:0]   sp_ax,
  output logic [NA-1:0]   pl_ax
);

  pstate_e         st;
  logic [LATW-1:0] cnt;
  logic [WINW-1:0] wc;
  logic [NA-1:0]   ax1;
  logic [NA-1:0]   ax2;
  logic            dbl;
  logic            dp_ev;
  logic            lat_hit;
  logic            win_hit;
  logic [LATW:0]   cnt_p1;
  logic [WINW:0]   wc_p1;

  always_comb begin
    dbl     = (win != '0);
    cnt_p1  = {1'b0, cnt} + (LATW+1)'(1);
    wc_p1   = {1'b0, wc} + (WINW+1)'(1);
    lat_hit = cnt_p1 >= {1'b0, lat};
    win_hit = wc_p1 >= {1'b0, win};
    sp_ev   = stb && (st == PS_HI1) && !cond;
    dp_ev   = stb && (st == PS_HI2) && !cond;
    pl_ev   = dbl ? dp_ev : sp_ev;
    sp_ax   = ax1;
    pl_ax   = dbl ? ax2 : ax1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= PS_IDLE;
      cnt <= '0;
      wc  <= '0;
      ax1 <= '0;
      ax2 <= '0;
    end else if (restart) begin
      st  <= PS_IDLE;
      cnt <= '0;
      wc  <= '0;
    end else if (stb) begin
      case (st)
        PS_IDLE: begin
          if (cond && (lat != '0)) begin
            st  <= PS_HI1;
            cnt <= '0;
            ax1 <= hit;
          end
        end
        PS_HI1: begin
          if (!cond) begin
            if (dbl) begin
              st <= PS_ARM;
              wc <= '0;
            end else begin
              st <= PS_IDLE;
            end
          end else if (lat_hit) begin
            st <= PS_WAITLO;
          end else begin
            cnt <= cnt + LATW'(1);
          end
        end
        PS_WAITLO: begin
          if (!cond) st <= PS_IDLE;
        end
        PS_ARM: begin
          if (cond) begin
            st  <= PS_HI2;
            cnt <= '0;
            ax2 <= hit;
          end else if (win_hit) begin
            st <= PS_IDLE;
          end else begin
            wc <= wc + WINW'(1);
          end
        end
        PS_HI2: begin
          if (!cond) begin
            st <= PS_IDLE;
          end else if (lat_hit) begin
            st <= PS_WAITLO;
          end else begin
            cnt <= cnt + LATW'(1);
          end
        end
        default: st <= PS_IDLE;
      endcase
    end
  end

  // R5: a pulse run only opens on a strobe carrying a true condition
  p_hi_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (st == PS_HI1 && $past(st) != PS_HI1) |-> $past(stb && cond))
    else $error("pulse run opened without a qualifying strobe");

endmodule

// File: rtl/mtl_flag_latch.sv
`timescale 1ns/1ps
module mtl_flag_latch #(
  parameter int NA = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          set,
  input  logic [NA-1:0] set_ax,
  output logic          flag,
  output logic [NA-1:0] ax,
  output logic          flag_nxt
);

  logic [NA-1:0] ax_nxt;

  always_comb begin
    flag_nxt = (flag & ~clr) | set;
    ax_nxt   = (ax & {NA{~clr}}) | (set ? set_ax : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      ax   <= '0;
    end else begin
      flag <= flag_nxt;
      ax   <= ax_nxt;
    end
  end

  // R9: a set flag survives every cycle without a clear
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag)
    else $error("flag dropped without a clear");

  // R8: source bits never outlive their flag
  p_src_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (ax != '0) |-> flag)
    else $error("source bits set with flag low");

endmodule

// File: rtl/motion_irq_latch.sv
`timescale 1ns/1ps
module motion_irq_latch
  import mtl_pkg::*;
#(
  parameter int DW   = 8,
  parameter int LATW = 4,
  parameter int WINW = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_vld,
  input  logic signed [DW-1:0] smp_x,
  input  logic signed [DW-1:0] smp_y,
  input  logic signed [DW-1:0] smp_z,
  input  logic [2:0]           axis_off,
  input  logic                 lvl_neg,
  input  logic                 thr_split,
  input  logic [DW-1:0]        lvl_thr_a,
  input  logic [DW-1:0]        lvl_thr_b,
  input  logic                 pls_neg,
  input  logic [DW-1:0]        pls_thr,
  input  logic [LATW-1:0]      pls_lat,
  input  logic [WINW-1:0]      dbl_win,
  input  logic [1:0]           src_sel,
  input  logic                 pin_cross,
  input  logic                 clr1,
  input  logic                 clr2,
  output logic                 flag1,
  output logic                 flag2,
  output logic [2:0]           src1,
  output logic [2:0]           src2,
  output logic                 irq_pin1,
  output logic                 irq_pin2
);

  localparam int NF = 2;

  logic signed [DW-1:0] smp_a [NAX];
  logic [NAX-1:0] lvl_bey, pls_bey, en;
  logic [NAX-1:0] lvl_hit, pls_hit;
  logic           lvl_cond, pls_cond, lvl_ev;
  logic           dbl, restart;
  logic           sp_ev, pl_ev;
  logic [NAX-1:0] sp_ax, pl_ax;
  logic [NF-1:0]  set_v, clr_v, flag_v, nxt_v;
  logic [NAX-1:0] sax [NF];
  logic [NAX-1:0] fax [NF];

  assign smp_a[0] = smp_x;
  assign smp_a[1] = smp_y;
  assign smp_a[2] = smp_z;

  for (genvar gi = 0; gi < NAX; gi++) begin : g_axis
    mtl_axis_cmp #(.DW(DW)) u_cmp (
      .smp     (smp_a[gi]),
      .thr_a   (lvl_thr_a),
      .thr_b   (lvl_thr_b),
      .pthr    (pls_thr),
      .split   (thr_split),
      .lvl_bey (lvl_bey[gi]),
      .pls_bey (pls_bey[gi])
    );
  end

  always_comb begin
    en       = ~axis_off;
    lvl_hit  = (lvl_neg ? ~lvl_bey : lvl_bey) & en;
    pls_hit  = (pls_neg ? ~pls_bey : pls_bey) & en;
    lvl_cond = lvl_neg ? ((en != '0) && (lvl_hit == en)) : (lvl_hit != '0);
    pls_cond = pls_neg ? ((en != '0) && (pls_hit == en)) : (pls_hit != '0);
    lvl_ev   = smp_vld && lvl_cond;
    dbl      = (dbl_win != '0);
    restart  = clr2 && dbl;
  end

  mtl_pulse_det #(.LATW(LATW), .WINW(WINW), .NA(NAX)) u_pls (
    .clk     (clk),
    .rst     (rst),
    .stb     (smp_vld),
    .cond    (pls_cond),
    .hit     (pls_hit),
    .lat     (pls_lat),
    .win     (dbl_win),
    .restart (restart),
    .sp_ev   (sp_ev),
    .pl_ev   (pl_ev),
    .sp_ax   (sp_ax),
    .pl_ax   (pl_ax)
  );

  always_comb begin
    set_v[0] = lvl_ev;
    sax[0]   = lvl_hit;
    set_v[1] = pl_ev;
    sax[1]   = pl_ax;
    case (src_sel_e'(src_sel))
      SRC_PLS_LVL: begin
        set_v[0] = pl_ev;
        sax[0]   = pl_ax;
        set_v[1] = lvl_ev;
        sax[1]   = lvl_hit;
      end
      SRC_SP_PLS: begin
        set_v[0] = sp_ev;
        sax[0]   = sp_ax;
      end
      default: ;
    endcase
    if (dbl) begin
      set_v[0] = sp_ev;
      sax[0]   = sp_ax;
    end
    clr_v[0] = dbl ? clr2 : clr1;
    clr_v[1] = clr2;
  end

  for (genvar gf = 0; gf < NF; gf++) begin : g_flag
    mtl_flag_latch #(.NA(NAX)) u_flag (
      .clk      (clk),
      .rst      (rst),
      .clr      (clr_v[gf]),
      .set      (set_v[gf]),
      .set_ax   (sax[gf]),
      .flag     (flag_v[gf]),
      .ax       (fax[gf]),
      .flag_nxt (nxt_v[gf])
    );
  end

  assign flag1 = flag_v[0];
  assign flag2 = flag_v[1];
  assign src1  = fax[0];
  assign src2  = fax[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pin1 <= 1'b0;
      irq_pin2 <= 1'b0;
    end else begin
      irq_pin1 <= pin_cross ? nxt_v[1] : nxt_v[0];
      irq_pin2 <= pin_cross ? nxt_v[0] : nxt_v[1];
    end
  end

  // R12: pins follow the flags through the routing chosen at the last edge
  p_pin_route_r12: assert property (@(posedge clk) disable iff (rst)
    (irq_pin1 == ($past(pin_cross) ? flag2 : flag1)) &&
    (irq_pin2 == ($past(pin_cross) ? flag1 : flag2)))
    else $error("pin routing mismatch");

  // R10: in double-pulse mode the first clear leaves flag1 alone
  p_clr1_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (dbl && flag1 && clr1 && !clr2) |=> flag1)
    else $error("clr1 acted in double-pulse mode");

  // R11: in double-pulse mode the second clear drops both flags
  p_clr2_both_r11: assert property (@(posedge clk) disable iff (rst)
    (dbl && clr2 && !smp_vld) |=> (!flag1 && !flag2))
    else $error("clr2 left a flag set in double-pulse mode");

endmodule

// File: tb/sim_motion_irq_latch.sv
`timescale 1ns/1ps
module sim_motion_irq_latch;

  localparam int DW   = 8;
  localparam int LATW = 4;
  localparam int WINW = 4;
  localparam int TA   = 40;
  localparam int TB   = 70;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 smp_vld = 1'b0;
  logic signed [DW-1:0] smp_x = '0;
  logic signed [DW-1:0] smp_y = '0;
  logic signed [DW-1:0] smp_z = '0;
  logic [2:0]           axis_off = '0;
  logic                 lvl_neg = 1'b0;
  logic                 thr_split = 1'b0;
  logic [DW-1:0]        lvl_thr_a = '0;
  logic [DW-1:0]        lvl_thr_b = '0;
  logic                 pls_neg = 1'b0;
  logic [DW-1:0]        pls_thr = '0;
  logic [LATW-1:0]      pls_lat = '0;
  logic [WINW-1:0]      dbl_win = '0;
  logic [1:0]           src_sel = '0;
  logic                 pin_cross = 1'b0;
  logic                 clr1 = 1'b0;
  logic                 clr2 = 1'b0;
  logic                 flag1, flag2, irq_pin1, irq_pin2;
  logic [2:0]           src1, src2;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  motion_irq_latch #(.DW(DW), .LATW(LATW), .WINW(WINW)) u0 (
    .clk(clk), .rst(rst), .smp_vld(smp_vld),
    .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
    .axis_off(axis_off), .lvl_neg(lvl_neg), .thr_split(thr_split),
    .lvl_thr_a(lvl_thr_a), .lvl_thr_b(lvl_thr_b),
    .pls_neg(pls_neg), .pls_thr(pls_thr), .pls_lat(pls_lat),
    .dbl_win(dbl_win), .src_sel(src_sel), .pin_cross(pin_cross),
    .clr1(clr1), .clr2(clr2),
    .flag1(flag1), .flag2(flag2), .src1(src1), .src2(src2),
    .irq_pin1(irq_pin1), .irq_pin2(irq_pin2)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic strobe(input int x, input int y, input int z);
    smp_x = DW'(x);
    smp_y = DW'(y);
    smp_z = DW'(z);
    smp_vld = 1'b1;
    tick();
    smp_vld = 1'b0;
  endtask

  task automatic clear(input logic c1, input logic c2);
    clr1 = c1;
    clr2 = c2;
    tick();
    clr1 = 1'b0;
    clr2 = 1'b0;
  endtask

  function automatic int wrap(input int v);
    logic signed [DW-1:0] t;
    t = DW'(v);
    return int'(t);
  endfunction

  function automatic bit beyond(input int a, input bit split);
    if (split) return (a >= TA) || (a <= -TB);
    return ((a < 0) ? -a : a) >= TA;
  endfunction

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    tick();
    tick();
    chk("R1 flag1", int'(flag1), 0);
    chk("R1 flag2", int'(flag2), 0);
    chk("R1 src1", int'(src1), 0);
    chk("R1 src2", int'(src2), 0);
    chk("R1 pin1", int'(irq_pin1), 0);
    chk("R1 pin2", int'(irq_pin2), 0);
    rst = 1'b0;
    tick();

    // R2 R3 R4 R8 R9: level sweep, clear and strobe in the same cycle
    lvl_thr_a = DW'(TA);
    lvl_thr_b = DW'(TB);
    pls_lat = '0;
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 3; c++) begin
        lvl_neg   = m[0];
        thr_split = m[1];
        axis_off  = (c == 0) ? 3'b000 : (c == 1) ? 3'b101 : 3'b111;
        for (int x = -128; x < 128; x++) begin
          int v [3];
          logic [2:0] h, en;
          logic ef;
          v[0] = x;
          v[1] = wrap(x * 3);
          v[2] = wrap(-x);
          en = ~axis_off;
          for (int i = 0; i < 3; i++)
            h[i] = (lvl_neg ? !beyond(v[i], thr_split) : beyond(v[i], thr_split)) & en[i];
          ef = lvl_neg ? ((en != 3'b000) && (h == en)) : (h != 3'b000);
          clr1 = 1'b1;
          strobe(v[0], v[1], v[2]);
          clr1 = 1'b0;
          chk("R2 R3 R4 R9 flag1", int'(flag1), int'(ef));
          chk("R2 R8 src1", int'(src1), ef ? int'(h) : 0);
        end
      end
    end
    clear(1'b1, 1'b0);

    // R9 R8: stickiness and accumulation of axes
    lvl_neg = 1'b0; thr_split = 1'b0; axis_off = 3'b000;
    strobe(100, 0, 0);
    chk("R9 set", int'(flag1), 1);
    for (int k = 0; k < 3; k++) begin
      strobe(0, 0, 0);
      chk("R9 sticky", int'(flag1), 1);
      chk("R9 sticky src", int'(src1), 1);
    end
    strobe(0, -100, 0);
    chk("R8 accumulate", int'(src1), 3);

    // R12: pin routing
    chk("R12 pin1 straight", int'(irq_pin1), 1);
    chk("R12 pin2 straight", int'(irq_pin2), 0);
    pin_cross = 1'b1;
    tick();
    chk("R12 pin1 crossed", int'(irq_pin1), 0);
    chk("R12 pin2 crossed", int'(irq_pin2), 1);
    pin_cross = 1'b0;
    tick();

    // R10: clr1 in single mode
    clear(1'b1, 1'b0);
    chk("R10 flag1 cleared", int'(flag1), 0);
    chk("R10 src1 cleared", int'(src1), 0);

    // R5: pulse length sweep, flag1 = pulse, flag2 = level (never hit)
    src_sel = 2'b01; lvl_thr_a = 8'd127; pls_thr = 8'd50; pls_lat = 4'd3;
    for (int len = 1; len <= 6; len++) begin
      clear(1'b1, 1'b1);
      strobe(0, 0, 0);
      for (int k = 0; k < len; k++) begin
        strobe(100, 0, 0);
        chk("R5 no early event", int'(flag1), 0);
      end
      strobe(0, 0, 0);
      chk("R5 pulse length", int'(flag1), (len <= 3) ? 1 : 0);
      chk("R8 pulse axes", int'(src1), (len <= 3) ? 1 : 0);
      chk("R7 level flag idle", int'(flag2), 0);
    end
    clear(1'b1, 1'b1);
    pls_lat = '0;
    strobe(100, 0, 0);
    strobe(0, 0, 0);
    chk("R5 latency zero", int'(flag1), 0);

    // R4 R5: negative pulse polarity, all axes inside
    pls_lat = 4'd3; pls_neg = 1'b1;
    strobe(100, 0, 0);
    strobe(0, 0, 0);
    strobe(0, 0, 0);
    chk("R5 neg no early", int'(flag1), 0);
    strobe(100, 0, 0);
    chk("R4 neg pulse", int'(flag1), 1);
    chk("R8 neg pulse axes", int'(src1), 7);
    pls_neg = 1'b0;
    strobe(0, 0, 0);
    clear(1'b1, 1'b1);

    // R7: source selection in single mode
    src_sel = 2'b00;
    strobe(100, 0, 0);
    strobe(0, 0, 0);
    chk("R7 sel00 flag1", int'(flag1), 0);
    chk("R7 sel00 flag2", int'(flag2), 1);
    clear(1'b1, 1'b1);
    src_sel = 2'b10;
    strobe(0, 0, -100);
    strobe(0, 0, 0);
    chk("R7 sel10 flag1", int'(flag1), 1);
    chk("R7 sel10 flag2", int'(flag2), 1);
    chk("R8 sel10 src2", int'(src2), 4);
    clear(1'b0, 1'b1);
    chk("R11 single clr2 keeps flag1", int'(flag1), 1);
    chk("R11 single clr2 flag2", int'(flag2), 0);
    clear(1'b1, 1'b0);
    src_sel = 2'b01; lvl_thr_a = 8'd40;
    strobe(60, 0, 0);
    chk("R7 sel01 level to flag2", int'(flag2), 1);
    chk("R7 sel01 flag1 pending", int'(flag1), 0);
    strobe(0, 0, 0);
    chk("R7 sel01 pulse to flag1", int'(flag1), 1);
    clear(1'b1, 1'b1);

    // R6 R7 R10 R11: double pulse window sweep
    src_sel = 2'b00; lvl_thr_a = 8'd127; pls_lat = 4'd2; dbl_win = 4'd4;
    for (int g = 0; g <= 5; g++) begin
      clear(1'b0, 1'b1);
      strobe(0, 0, 0);
      strobe(100, 0, 0);
      strobe(0, 0, 0);
      chk("R6 first pulse flag1", int'(flag1), 1);
      chk("R6 first pulse flag2", int'(flag2), 0);
      for (int k = 0; k < g; k++) strobe(0, 0, 0);
      strobe(0, -100, 0);
      strobe(0, 0, 0);
      chk("R6 window", int'(flag2), (g <= 3) ? 1 : 0);
      chk("R8 second pulse axes", int'(src2), (g <= 3) ? 2 : 0);
    end
    clear(1'b1, 1'b0);
    chk("R10 clr1 ignored", int'(flag1), 1);
    chk("R10 clr1 ignored src", int'(src1), 3);
    clear(1'b0, 1'b1);
    chk("R11 clr2 flag1", int'(flag1), 0);
    chk("R11 clr2 src1", int'(src1), 0);
    strobe(100, 0, 0);
    strobe(0, 0, 0);
    clear(1'b0, 1'b1);
    strobe(100, 0, 0);
    strobe(0, 0, 0);
    chk("R11 restart flag1", int'(flag1), 1);
    chk("R11 restart flag2", int'(flag2), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule